// File: doc/BRIEF.md
# H-Bridge Direction and Carrier Controller

This block converts two active-low direction commands and a serial data line into the four gate enables of a single H-bridge. The bridge drives a DC motor in one of two directions and also energises a magnetic-link antenna coil wired across the same bridge outputs. When exactly one direction command is low, the bridge runs the motor that way. Pulling both commands low switches the block into transmit mode. In that mode the bridge stays dark while the serial line idles high. A low serial line keys an on-off carrier that reverses the coil current on every half period.

The carrier comes from the system clock through a divider with a parameterised half period. At an 8 MHz clock a half period of 40 clocks gives 100 kHz. Every change of bridge direction passes through a parameterised dead-time with all four enables off, so the two switches of one bridge side never conduct together. A separate request selects the higher (stacked) bridge supply in place of the lower one.

Top module: `hbridge_steer`

## Requirements
- R1: With `close_n` low and `open_n` high, the enables settle to upper-left and lower-right on, with upper-right and lower-left off. Read as {ul,ur,ll,lr}, that is 4'b1001.
- R2: With `open_n` low and `close_n` high, the enables settle to upper-right and lower-left on, with the other two off. Read as {ul,ur,ll,lr}, that is 4'b0110.
- R3: In motor mode (at most one command low), the level of `ser_in` has no effect on the enables. With neither command low, all four enables are off.
- R4: With both commands low and `ser_in` high, all four enables stay off.
- R5: With both commands low and `ser_in` low, the bridge alternates between the close pattern and the open pattern, starting with the close pattern. Each full reversal cycle lasts exactly 2*HALF_DIV clocks.
- R6: The enables never go directly from one direction to the other. Each change of direction holds all four enables off for at least DEAD_CLKS clocks. Upper-left and lower-left are never on together, and neither are upper-right and lower-right.
- R7: After `ser_in` returns high in transmit mode, the carrier finishes its current half period and then stops. All enables are off no later than HALF_DIV+DEAD_CLKS+4 clocks afterwards, and they stay off.
- R8: `sup_hi` equals the value `dbl_req` had at the previous rising clock edge.
- R9: While `rst_n` is low, all four enables and `sup_hi` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| close_n | input | 1 | Close-direction command, active low |
| open_n | input | 1 | Open-direction command, active low |
| ser_in | input | 1 | Serial data line, idle high; low keys the carrier |
| dbl_req | input | 1 | Request for the higher bridge supply |
| leg_ul | output | 1 | Upper-left switch enable |
| leg_ur | output | 1 | Upper-right switch enable |
| leg_ll | output | 1 | Lower-left switch enable |
| leg_lr | output | 1 | Lower-right switch enable |
| sup_hi | output | 1 | Selects the higher bridge supply |

## Verification
The hardest condition to reach from the ports is the carrier stopping partway through a half period. The serial line must rise while the divider is mid-count, and the enables must then run to the boundary and settle off, with dead-time still in force. The bench starts a keyed carrier and raises `ser_in` at an arbitrary point in a half period. It then bounds the cycle in which the enables go dark and watches that they stay dark. A monitor that runs throughout every scenario measures the off-gap at each reversal and flags any same-side conduction.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [1:0] {
        DIR_OFF   = 2'd0,
        DIR_CLOSE = 2'd1,
        DIR_OPEN  = 2'd2
    } dir_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '1;   // line idles high
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/hb_carrier.sv
module hb_carrier #(
    parameter int HALF_DIV = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_i,
    input  logic key_i,     // synchronised serial line is low
    output logic run_o,
    output logic osc_o
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    typedef struct packed {
        logic          run;
        logic          osc;
        logic [CW-1:0] cnt;
    } car_t;

    car_t car_d, car_q;

    always_comb begin
        car_d = car_q;
        if (!tx_i) begin
            car_d = '0;
        end else if (!car_q.run) begin
            if (key_i) begin
                car_d.run = 1'b1;
                car_d.osc = 1'b0;
                car_d.cnt = '0;
            end
        end else if (car_q.cnt == LAST) begin
            car_d.cnt = '0;
            if (key_i) begin
                car_d.osc = ~car_q.osc;
            end else begin
                car_d.run = 1'b0;
                car_d.osc = 1'b0;
            end
        end else begin
            car_d.cnt = car_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) car_q <= '0;
        else        car_q <= car_d;
    end

    assign run_o = car_q.run;
    assign osc_o = car_q.osc;

    // R5: oscillator level holds for the whole half period
    assert_half_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (car_q.run && tx_i && car_q.cnt != LAST) |=> $stable(car_q.osc));
    // R3: outside transmit mode the oscillator is parked low
    assert_park_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_i |=> (!osc_o && !run_o));
    // R7: a stop only happens at a half-period boundary
    assert_stop_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (car_q.run && tx_i && car_q.cnt != LAST) |=> run_o);
endmodule

// File: rtl/hb_legs.sv
module hb_legs
    import hb_pkg::*;
#(
    parameter int DEAD_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  dir_e       req_i,
    output logic [3:0] legs_o   // {ul, ur, ll, lr}
);
    localparam int DW = $clog2(DEAD_CLKS + 1) < 1 ? 1 : $clog2(DEAD_CLKS + 1);

    typedef struct packed {
        dir_e          cur;
        logic [DW-1:0] dead;
    } leg_t;

    leg_t leg_d, leg_q;

    always_comb begin
        leg_d = leg_q;
        if (leg_q.dead != '0) leg_d.dead = leg_q.dead - 1'b1;
        if (req_i != leg_q.cur) begin
            if (leg_q.cur != DIR_OFF) begin
                leg_d.cur  = DIR_OFF;
                leg_d.dead = DW'(DEAD_CLKS);
            end else if (leg_q.dead == '0) begin
                leg_d.cur = req_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) leg_q <= '{cur: DIR_OFF, dead: '0};
        else        leg_q <= leg_d;
    end

    always_comb begin
        unique case (leg_q.cur)
            DIR_CLOSE: legs_o = 4'b1001;
            DIR_OPEN:  legs_o = 4'b0110;
            default:   legs_o = 4'b0000;
        endcase
    end

    // R6: no direct reversal between directions
    assert_no_reverse_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_q.cur == DIR_CLOSE) |=> (leg_q.cur != DIR_OPEN));
    assert_no_reverse_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_q.cur == DIR_OPEN) |=> (leg_q.cur != DIR_CLOSE));
    // R6: bridge stays dark while dead-time runs
    assert_dead_dark_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (leg_q.cur == DIR_OFF && leg_q.dead != '0) |=> (legs_o == 4'b0000));
    // R6: never both switches of one side
    assert_side_safe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !((legs_o[3] && legs_o[1]) || (legs_o[2] && legs_o[0])));
endmodule

// File: rtl/hbridge_steer.sv
module hbridge_steer
    import hb_pkg::*;
#(
    parameter int HALF_DIV  = 40,
    parameter int DEAD_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic close_n,
    input  logic open_n,
    input  logic ser_in,
    input  logic dbl_req,
    output logic leg_ul,
    output logic leg_ur,
    output logic leg_ll,
    output logic leg_lr,
    output logic sup_hi
);
    typedef struct packed {
        logic sup;
    } top_t;

    top_t top_d, top_q;
    logic ser_s, tx_mode, run, osc;
    dir_e req;
    logic [3:0] legs;

    assign tx_mode = !close_n && !open_n;

    hb_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(ser_in), .q_o(ser_s)
    );

    hb_carrier #(.HALF_DIV(HALF_DIV)) u_car (
        .clk(clk), .rst_n(rst_n), .tx_i(tx_mode), .key_i(!ser_s),
        .run_o(run), .osc_o(osc)
    );

    always_comb begin
        if (tx_mode)       req = run ? (osc ? DIR_OPEN : DIR_CLOSE) : DIR_OFF;
        else if (!close_n) req = DIR_CLOSE;   // close wins, open path forced off
        else if (!open_n)  req = DIR_OPEN;
        else               req = DIR_OFF;
    end

    hb_legs #(.DEAD_CLKS(DEAD_CLKS)) u_legs (
        .clk(clk), .rst_n(rst_n), .req_i(req), .legs_o(legs)
    );

    always_comb begin
        top_d     = top_q;
        top_d.sup = dbl_req;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) top_q <= '0;
        else        top_q <= top_d;
    end

    assign {leg_ul, leg_ur, leg_ll, leg_lr} = legs;
    assign sup_hi = top_q.sup;

    // R8: supply select follows the request one clock later
    assert_sup_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbl_req |=> sup_hi);
    assert_sup_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dbl_req |=> !sup_hi);
    // R4: transmit with a parked oscillator leaves the bridge dark
    assert_tx_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_mode && !run) |-> (req == DIR_OFF));
endmodule

// File: tb/hbridge_steer_tb.sv
module hbridge_steer_tb;
    localparam int HALF = 10;
    localparam int DEAD = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic close_n = 1'b1, open_n = 1'b1, ser_in = 1'b1, dbl_req = 1'b0;
    logic leg_ul, leg_ur, leg_ll, leg_lr, sup_hi;
    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit done = 0;
    int shoot = 0, gapbad = 0, last_dir = 0, offrun = 0;

    always #10 clk = ~clk;   // 50 MHz
    always @(posedge clk) cyc <= cyc + 1;

    hbridge_steer #(.HALF_DIV(HALF), .DEAD_CLKS(DEAD)) u_dut (
        .clk(clk), .rst_n(rst_n), .close_n(close_n), .open_n(open_n),
        .ser_in(ser_in), .dbl_req(dbl_req),
        .leg_ul(leg_ul), .leg_ur(leg_ur), .leg_ll(leg_ll), .leg_lr(leg_lr),
        .sup_hi(sup_hi)
    );

    function automatic logic [3:0] legs();
        return {leg_ul, leg_ur, leg_ll, leg_lr};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // R6 monitor: same-side conduction and off-gap at reversals
    always @(negedge clk) if (rst_n) begin
        int d;
        if ((leg_ul && leg_ll) || (leg_ur && leg_lr)) shoot++;
        d = (legs() == 4'b1001) ? 1 : (legs() == 4'b0110) ? 2 : 0;
        if (d == 0) offrun++;
        else begin
            if (last_dir != 0 && d != last_dir && offrun < DEAD) gapbad++;
            last_dir = d;
            offrun = 0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();   // R9
        @(negedge clk);
        check(legs() == 4'b0000, "R9 legs in reset", legs(), 0);
        check(sup_hi == 1'b0, "R9 sup_hi in reset", sup_hi, 0);
        rst_n = 1'b1;
        wait_cyc(3);
        check(legs() == 4'b0000, "R3 no command, all off", legs(), 0);
    endtask

    task automatic t_close();   // R1
        close_n = 1'b0; open_n = 1'b1;
        wait_cyc(DEAD + 4);
        check(legs() == 4'b1001, "R1 close pattern", legs(), 4'b1001);
    endtask

    task automatic t_open();    // R2, reversal from close
        open_n = 1'b0; close_n = 1'b1;
        wait_cyc(1);
        check(legs() == 4'b0000, "R6 dark right after reversal", legs(), 0);
        wait_cyc(DEAD + 4);
        check(legs() == 4'b0110, "R2 open pattern", legs(), 4'b0110);
        open_n = 1'b1;
        wait_cyc(DEAD + 4);
    endtask

    task automatic t_motor_ser();   // R3
        int bad = 0;
        close_n = 1'b0; ser_in = 1'b0;
        wait_cyc(DEAD + 4);
        for (int i = 0; i < 5 * HALF; i++) begin
            @(negedge clk);
            if (legs() != 4'b1001) bad++;
        end
        check(bad == 0, "R3 serial low ignored in motor mode", bad, 0);
        ser_in = 1'b1; close_n = 1'b1;
        wait_cyc(DEAD + 4);
    endtask

    task automatic t_tx_idle();     // R4
        int bad = 0;
        ser_in = 1'b1; close_n = 1'b0; open_n = 1'b0;
        for (int i = 0; i < 4 * HALF; i++) begin
            @(negedge clk);
            if (legs() != 4'b0000) bad++;
        end
        check(bad == 0, "R4 transmit idle stays dark", bad, 0);
    endtask

    task automatic t_tx_carrier();  // R5, R7
        int t0, t1, t2, lim, bad, first;
        logic [3:0] prev;
        ser_in = 1'b0;
        first = -1;
        prev = legs();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (first < 0 && legs() != 4'b0000) first = legs();
        end
        check(first == 4'b1001, "R5 first phase is close", first, 4'b1001);
        // measure reversal period between close-phase starts
        prev = legs();
        t0 = -1; t1 = -1; t2 = -1;
        for (int i = 0; i < 8 * HALF; i++) begin
            @(negedge clk);
            if (legs() == 4'b1001 && prev != 4'b1001) begin
                if (t0 < 0) t0 = cyc; else if (t1 < 0) t1 = cyc; else if (t2 < 0) t2 = cyc;
            end
            prev = legs();
        end
        check(t1 - t0 == 2 * HALF, "R5 carrier period", t1 - t0, 2 * HALF);
        check(t2 - t1 == 2 * HALF, "R5 carrier period repeat", t2 - t1, 2 * HALF);
        // stop mid half-period
        wait_cyc(3);
        ser_in = 1'b1;
        lim = HALF + DEAD + 4;
        wait_cyc(lim);
        bad = 0;
        for (int i = 0; i < 4 * HALF; i++) begin
            @(negedge clk);
            if (legs() != 4'b0000) bad++;
        end
        check(bad == 0, "R7 carrier stops and stays dark", bad, 0);
        close_n = 1'b1; open_n = 1'b1;
        wait_cyc(DEAD + 4);
    endtask

    task automatic t_supply();      // R8
        dbl_req = 1'b1;
        @(negedge clk);
        check(sup_hi == 1'b1, "R8 high supply selected", sup_hi, 1);
        dbl_req = 1'b0;
        @(negedge clk);
        check(sup_hi == 1'b0, "R8 low supply selected", sup_hi, 0);
    endtask

    initial begin
        t_reset();
        t_close();
        t_open();
        t_motor_ser();
        t_tx_idle();
        t_tx_carrier();
        t_supply();
        check(shoot == 0, "R6 same-side conduction", shoot, 0);
        check(gapbad == 0, "R6 dead-time gap", gapbad, 0);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule